// File: doc/BRIEF.md
# Nested Priority Interrupt Level Controller

This block sits between seven interrupt request lines and a processor core. It folds the active requests into one three-bit priority code, driven active-low, and it tracks the processor's current interrupt mask level. It drives a code only when the highest pending level is above the mask, or when that level is the top, non-maskable level.

When the core accepts an interrupt, it pulses `ack`. The controller then raises the mask to the serviced level and saves the old mask on an internal stack. When the handler finishes, a `ret` pulse pops the stack and restores the saved mask. Any request that was held back while the handler ran can then be presented. Software can also overwrite the mask directly through a load port.

Top module: `nested_irq_ctrl`

## Requirements
- R1: When several lines are active, the presented level is the highest active level number (line bit i is level i+1). All lower levels are ignored.
- R2: `ipl_n` carries the bitwise inverse of the presented level. It is 3'b111 when nothing is presented, and 3'b000 for level 7.
- R3: A level p from 1 to 6 is presented only when p is greater than the current mask. Level 7 is presented at any mask, including mask 7. Otherwise `ipl_n` is 3'b111.
- R4: An `ack` while a level is presented pushes the old mask, and the mask equals that level from the next cycle on. An `ack` while nothing is presented has no effect.
- R5: A `ret` with a non-empty stack pops it, so the mask equals the value saved by the matching acknowledge from the next cycle on. A held lower request is then presented if it is above the restored mask.
- R6: After reset the mask is 0, the stack is empty, `ipl_n` is 3'b111 until a line is active, and both error outputs are 0.
- R7: Level 7 becomes pending on a rising edge of its line and stays pending until a level-7 acknowledge is accepted. A line held high does not make it pending again. Levels 1 to 6 follow their lines directly.
- R8: With `DEPTH` masks saved, an acknowledge that would otherwise be accepted is dropped. Mask, stack and level-7 pending state stay unchanged, and `err_ovf` is 1 for exactly the next cycle.
- R9: A `ret` with an empty stack leaves the mask and stack unchanged, and `err_unf` is 1 for exactly the next cycle.
- R10: A `mask_ld` sets the mask to `mask_din` on the next cycle. An `ack` or `ret` in the same cycle has no effect.
- R11: When an accepted `ack` and a `ret` arrive in the same cycle, the acknowledge takes effect and the `ret` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 7 | Request lines; bit i is level i+1 |
| ack | input | 1 | Core accepts the presented interrupt |
| ret | input | 1 | Handler return strobe |
| mask_ld | input | 1 | Direct mask load strobe |
| mask_din | input | 3 | Value for direct mask load |
| ipl_n | output | 3 | Active-low presented priority level |
| mask | output | 3 | Current interrupt mask |
| err_ovf | output | 1 | One-cycle flag: acknowledge dropped because the stack is full |
| err_unf | output | 1 | One-cycle flag: return with an empty stack |

## Verification
A corrupted stack entry stays hidden until its `ret`. At that point `mask` shows the wrong value in the next cycle, and `ipl_n` presents or withholds a held request incorrectly in that same cycle. A wrong depth count shows up as a missing or early `err_ovf`/`err_unf` pulse, one cycle after the strobe. A stuck level-7 pending bit shows up either as repeated level-7 presentation with the line held high, or as a missed edge. Each step compares `ipl_n` before the clock edge and compares `mask` and both error flags after it, so any divergence is caught within the cycle it appears in.

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
  parameter int LEVELS = 7,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] irq_req,
  input  logic              ack,
  input  logic              ret,
  input  logic              mask_ld,
  input  logic [$clog2(LEVELS+1)-1:0] mask_din,
  output logic [$clog2(LEVELS+1)-1:0] ipl_n,
  output logic [$clog2(LEVELS+1)-1:0] mask,
  output logic              err_ovf,
  output logic              err_unf
);
  localparam int LW = $clog2(LEVELS+1);
  localparam int PW = $clog2(DEPTH+1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [LW-1:0] TOP = LW'(LEVELS);

  logic [LW-1:0] mask_q;
  logic [LW-1:0] stk [2**AW];
  logic [PW-1:0] depth_q;
  logic          top_q, top_pend;
  logic [LEVELS-1:0] eff;
  logic [LW-1:0] hi;
  logic          recog, take, push_ok, ovf, do_ret, pop_ok, unf, top_rise;

  assign eff = {top_pend, irq_req[LEVELS-2:0]};

  always_comb begin
    hi = '0;
    for (int i = 0; i < LEVELS; i++)
      if (eff[i]) hi = LW'(i + 1);
  end

  assign recog    = (hi != '0) && ((hi > mask_q) || (hi == TOP));
  assign ipl_n    = recog ? ~hi : '1;
  assign mask     = mask_q;
  assign take     = ack && recog && !mask_ld;
  assign push_ok  = take && (depth_q != PW'(DEPTH));
  assign ovf      = take && (depth_q == PW'(DEPTH));
  assign do_ret   = ret && !mask_ld && !take;
  assign pop_ok   = do_ret && (depth_q != '0);
  assign unf      = do_ret && (depth_q == '0);
  assign top_rise = irq_req[LEVELS-1] && !top_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      depth_q  <= '0;
      top_q    <= 1'b0;
      top_pend <= 1'b0;
      err_ovf  <= 1'b0;
      err_unf  <= 1'b0;
    end else begin
      top_q   <= irq_req[LEVELS-1];
      err_ovf <= ovf;
      err_unf <= unf;
      if (top_rise) top_pend <= 1'b1;
      else if (push_ok && hi == TOP) top_pend <= 1'b0;
      if (mask_ld) mask_q <= mask_din;
      else if (push_ok) begin
        mask_q  <= hi;
        depth_q <= depth_q + 1'b1;
      end else if (pop_ok) begin
        mask_q  <= stk[AW'(depth_q - 1'b1)];
        depth_q <= depth_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (push_ok) stk[AW'(depth_q)] <= mask_q;

  assert_code_above_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_n != '1) |-> ((~ipl_n > mask) || (~ipl_n == TOP)));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= PW'(DEPTH));
  assert_ovf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |-> ($stable(mask) && $stable(depth_q)));
  assert_unf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_unf |-> ($stable(mask) && $stable(depth_q)));
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ld |=> (mask == $past(mask_din)));
  assert_take_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !mask_ld && ipl_n != '1 && depth_q != PW'(DEPTH)) |=> (mask == ~$past(ipl_n)));
endmodule

// File: tb/nested_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nested_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic [6:0] irq_req = '0;
  logic ack = 0, ret = 0, mask_ld = 0;
  logic [2:0] mask_din = '0;
  logic [2:0] ipl_n, mask;
  logic err_ovf, err_unf;

  nested_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ack(ack), .ret(ret),
    .mask_ld(mask_ld), .mask_din(mask_din), .ipl_n(ipl_n), .mask(mask),
    .err_ovf(err_ovf), .err_unf(err_unf));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_mask, m_depth, m_stk[8];
  bit m_pend, m_r7;

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int m_hi(logic [6:0] r);
    int h = 0;
    for (int i = 0; i < 6; i++) if (r[i]) h = i + 1;
    if (m_pend) h = 7;
    return h;
  endfunction

  function automatic bit m_recog(int h);
    return (h != 0) && (h > m_mask || h == 7);
  endfunction

  task automatic model_reset();
    m_mask = 0; m_depth = 0; m_pend = 0; m_r7 = 0;
  endtask

  task automatic step(logic [6:0] r, bit a, bit rt, bit ld, logic [2:0] din);
    int h, exp_ipl;
    bit rc, tk, psh, ov, dr, pp, uf;
    string tag;
    @(negedge clk);
    irq_req = r; ack = a; ret = rt; mask_ld = ld; mask_din = din;
    #1;
    h = m_hi(r); rc = m_recog(h);
    exp_ipl = rc ? (~h & 7) : 7;
    tag = (h == 7) ? "R7" : (h == 0) ? "R2" : !rc ? "R3" : "R1";
    check(tag, int'(ipl_n), exp_ipl);
    tk = a && rc && !ld; psh = tk && m_depth < 8; ov = tk && m_depth == 8;
    dr = rt && !ld && !tk; pp = dr && m_depth > 0; uf = dr && m_depth == 0;
    @(posedge clk);
    if (r[6] && !m_r7) m_pend = 1; else if (psh && h == 7) m_pend = 0;
    m_r7 = r[6];
    if (ld) m_mask = din;
    else if (psh) begin m_stk[m_depth] = m_mask; m_depth++; m_mask = h; end
    else if (pp) begin m_depth--; m_mask = m_stk[m_depth]; end
    #1;
    tag = ld ? "R10" : (tk && rt) ? "R11" : pp ? "R5" : "R4";
    check(tag, int'(mask), m_mask);
    check("R8", int'(err_ovf), int'(ov));
    check("R9", int'(err_unf), int'(uf));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; irq_req = '0; ack = 0; ret = 0; mask_ld = 0;
    model_reset();
    #1;
    check("R6", int'(ipl_n), 7);
    check("R6", int'(mask), 0);
    check("R6", int'(err_ovf) + int'(err_unf), 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (2) @(posedge clk);
    do_reset();
    // nesting: level 2, then 5 over it, 4 held until 5 returns
    step(7'b0000010, 1, 0, 0, 0);
    step(7'b0010010, 1, 0, 0, 0);
    step(7'b0001010, 0, 0, 0, 0);
    step(7'b0001010, 0, 1, 0, 0);
    step(7'b0001010, 1, 0, 0, 0);
    step(7'b0000010, 0, 1, 0, 0);
    step(7'b0000010, 0, 1, 0, 0);
    step(7'b0000000, 0, 1, 0, 0);   // underflow, R9
    // R11: ack with ret together
    step(7'b0000100, 1, 1, 0, 0);
    // R10: load beats ack and ret
    step(7'b0100000, 1, 1, 1, 3'd7);
    step(7'b0100000, 0, 0, 0, 0);   // R3: level 6 under mask 7
    do_reset();
    // R7 and R8: nest level 7 on fresh edges until overflow
    for (int k = 0; k < 9; k++) begin
      step(7'b1000000, 0, 0, 0, 0);
      step(7'b1000000, 1, 0, 0, 0);
      step(7'b1000000, 1, 0, 0, 0);  // held line: no re-entry
      step(7'b0000000, 0, 0, 0, 0);
    end
    step(7'b1000000, 0, 0, 0, 0);
    step(7'b1000000, 1, 0, 0, 0);   // pending again after overflow
    for (int k = 0; k < 10; k++) step(7'b0000000, 0, 1, 0, 0);
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] r;
      r = 7'($urandom);
      if ($urandom_range(3) != 0) r[6] = 0;
      step(r, $urandom_range(2) == 0, $urandom_range(3) == 0,
           $urandom_range(15) == 0, 3'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule